// File: doc/BRIEF.md
# Pending Interrupt Vector Tracker

This block keeps the request state of a 256-entry interrupt vector space: one bit per vector, plus a summary flag saying whether any request is outstanding. A requester raises a vector through the set port. In the same cycle the port reports whether that vector was already requested, so the caller can spot a repeated request. A consumer retires a vector through the clear port. The query side always shows the highest-numbered outstanding vector, computed from registered state.

The summary flag lets the query skip the search. When the flag is low, the query reports "none", encoded as all ones on a signed-style output one bit wider than a vector number. A set always raises the flag. A clear recomputes the flag from the bitmap that remains after the bit is removed. Vectors below 16 are reserved: an attempt to set one leaves the state alone and produces a one-cycle error pulse.

Top module: `pend_vec_tracker`

## Requirements
- R1: A synchronous active-low reset clears every vector bit and drops the summary flag. After reset `pending`, `top_valid` and `set_err` are 0, and `top_vec` is 9'h1FF ("none").
- R2: A set of a legal vector (16 to 255) records it. From the next cycle the query includes that vector.
- R3: `set_dup` is combinational. It is 1 in the cycle of a legal set whose vector bit is already recorded, and 0 otherwise (no set, a new vector, or a reserved vector).
- R4: After any legal set, `pending` is 1 in the next cycle, whatever else happened in that cycle.
- R5: When `top_valid` is 1, `top_vec[8]` is 0 and `top_vec[7:0]` is the highest-numbered recorded vector, always 16 or more. Several recorded vectors resolve to the largest number.
- R6: A clear removes its vector. In the next cycle the query shows the highest remaining vector, and `pending` stays 1 if any vector remains. When none remains, `pending` and `top_valid` drop and `top_vec` is 9'h1FF.
- R7: While `pending` is 0, the query reports none (`top_valid` 0, `top_vec` 9'h1FF).
- R8: A set of a vector below 16 records nothing. `set_err` is 1 for exactly the one cycle after that request, and 0 after any cycle without such a request.
- R9: When a legal set and a clear name the same vector in one cycle, the set wins. The vector stays recorded and `pending` stays 1.
- R10: A clear of a vector that is not recorded changes nothing seen at the query.
- R11: The query reflects set and clear only from the cycle after the request. In the request cycle it still shows the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_en | input | 1 | Set request strobe |
| set_vec | input | 8 | Vector to set |
| clr_en | input | 1 | Clear request strobe |
| clr_vec | input | 8 | Vector to clear |
| set_dup | output | 1 | Set targets a vector already recorded |
| set_err | output | 1 | One-cycle pulse after a set of a reserved vector |
| pending | output | 1 | Summary flag: some vector is recorded |
| top_valid | output | 1 | Query result is a vector |
| top_vec | output | 9 | Highest recorded vector, or all ones for none |

## Verification
A corrupted bitmap bit shows at the ports in one of two ways. It can surface at once on `set_dup` when that vector is set again. Otherwise it shows on `top_vec` one cycle after the clears that expose it as the highest remaining vector. A stale summary flag shows up as a wrong `top_valid` in the cycle after the last clear. The bench therefore empties the bitmap several times and checks the "none" encoding right after each emptying. It also checks the duplicate flag on vectors that were set, cleared and set again.

// File: rtl/pvt_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the pending-flag update selector for the
// pending vector tracker. Assumes nothing beyond plain SystemVerilog.
package pvt_pkg;
    localparam int DEF_NUM_VEC = 256;
    localparam int DEF_GROUP_W = 32;
    localparam int DEF_RSVD    = 16;

    // Where the next value of the summary flag comes from.
    typedef enum logic [1:0] {
        PND_HOLD   = 2'd0,
        PND_SET    = 2'd1,
        PND_RESCAN = 2'd2
    } pnd_src_e;
endpackage

// File: rtl/pvt_group_enc.sv
`timescale 1ns/1ps
// Module: highest-set-bit encoder for one word.
// Assumes W is a power of two and at least 2. idx is 0 when no bit is set.
module pvt_group_enc #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so that the last hit, the highest bit, sets the index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (word[i]) idx = IW'(i);
        end
    end

    // Any-bit flag for the word.
    assign any = |word;
endmodule

// File: rtl/pvt_search.sv
`timescale 1ns/1ps
// Module: two-level search for the highest set vector.
// Level one encodes each GROUP_W-bit group. Level two picks the highest
// non-empty group. The result is the group number joined with the
// in-group index. Assumes NUM_VEC / GROUP_W is a power of two and at least 2.
// The module is purely combinational.
module pvt_search #(
    parameter int NUM_VEC = pvt_pkg::DEF_NUM_VEC,
    parameter int GROUP_W = pvt_pkg::DEF_GROUP_W,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int NGRP   = NUM_VEC / GROUP_W,
    localparam int GIW    = $clog2(GROUP_W),
    localparam int GSW    = $clog2(NGRP)
) (
    input  logic [NUM_VEC-1:0] bits,
    output logic               found,
    output logic [VEC_W-1:0]   top
);
    logic [NGRP-1:0]          grp_any;
    logic [NGRP-1:0][GIW-1:0] grp_idx;
    logic [GSW-1:0]           win_grp;

    // Level one: one encoder per group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pvt_group_enc #(.W(GROUP_W)) u_enc (
            .word (bits[g*GROUP_W +: GROUP_W]),
            .any  (grp_any[g]),
            .idx  (grp_idx[g])
        );
    end

    // Level two: choose the highest group that holds a set bit.
    pvt_group_enc #(.W(NGRP)) u_sel (
        .word (grp_any),
        .any  (found),
        .idx  (win_grp)
    );

    // Join the group number with the index inside that group.
    assign top = {win_grp, grp_idx[win_grp]};
endmodule

// File: rtl/pvt_store.sv
`timescale 1ns/1ps
// Module: request bitmap and summary flag registers.
// A set has priority over a clear of the same vector. A set raises the flag.
// A clear without a set recomputes the flag from the bitmap that remains.
// Assumes the caller has already screened out reserved vectors from set_ok.
module pvt_store #(
    parameter int NUM_VEC = pvt_pkg::DEF_NUM_VEC,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_ok,
    input  logic [VEC_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [VEC_W-1:0]   clr_idx,
    output logic [NUM_VEC-1:0] bits_q,
    output logic               pend_q
);
    import pvt_pkg::*;

    logic [NUM_VEC-1:0] bits_n;
    pnd_src_e           pnd_src;

    // Next bitmap: apply the clear first, then the set, so the set wins.
    always_comb begin
        bits_n = bits_q;
        if (clr_en) bits_n[clr_idx] = 1'b0;
        if (set_ok) bits_n[set_idx] = 1'b1;
    end

    // Choose how the summary flag is updated this cycle.
    always_comb begin
        if (set_ok)      pnd_src = PND_SET;
        else if (clr_en) pnd_src = PND_RESCAN;
        else             pnd_src = PND_HOLD;
    end

    // Register the bitmap and the summary flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            pend_q <= 1'b0;
        end else begin
            bits_q <= bits_n;
            case (pnd_src)
                PND_SET:    pend_q <= 1'b1;
                PND_RESCAN: pend_q <= |bits_n;
                default:    pend_q <= pend_q;
            endcase
        end
    end
endmodule

// File: rtl/pend_vec_tracker.sv
`timescale 1ns/1ps
// Module: pending interrupt vector tracker (top).
// Screens set requests against the reserved range and reports repeated sets
// combinationally. Raises a registered one-cycle error for reserved vectors.
// Presents the highest recorded vector, computed from registered state only.
// When the summary flag is low, the query reports all ones.
module pend_vec_tracker #(
    parameter int NUM_VEC = pvt_pkg::DEF_NUM_VEC,
    parameter int GROUP_W = pvt_pkg::DEF_GROUP_W,
    parameter int RSVD    = pvt_pkg::DEF_RSVD,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_vec,
    output logic             set_dup,
    output logic             set_err,
    output logic             pending,
    output logic             top_valid,
    output logic [VEC_W:0]   top_vec
);
    logic               legal;
    logic               set_ok;
    logic               set_bad;
    logic [NUM_VEC-1:0] bits_q;
    logic               pend_q;
    logic               found;
    logic [VEC_W-1:0]   srch_top;

    // Classify the set request against the reserved range.
    always_comb begin
        legal   = (int'(set_vec) >= RSVD);
        set_ok  = set_en && legal;
        set_bad = set_en && !legal;
    end

    pvt_store #(.NUM_VEC(NUM_VEC)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ok  (set_ok),
        .set_idx (set_vec),
        .clr_en  (clr_en),
        .clr_idx (clr_vec),
        .bits_q  (bits_q),
        .pend_q  (pend_q)
    );

    pvt_search #(.NUM_VEC(NUM_VEC), .GROUP_W(GROUP_W)) u_search (
        .bits  (bits_q),
        .found (found),
        .top   (srch_top)
    );

    // Test-and-set answer: was the requested bit already recorded?
    assign set_dup = set_ok && bits_q[set_vec];

    // One-cycle error pulse after a reserved-vector set.
    always_ff @(posedge clk) begin
        if (!rst_n) set_err <= 1'b0;
        else        set_err <= set_bad;
    end

    // Query: the summary flag gates the search result.
    always_comb begin
        pending   = pend_q;
        top_valid = pend_q && found;
        top_vec   = top_valid ? {1'b0, srch_top} : '1;
    end
endmodule

// File: rtl/pvt_checker.sv
`timescale 1ns/1ps
// Module: port-level property checker for pend_vec_tracker, bound to every
// instance. Assumes the reset is held low for at least the first clock edge.
module pvt_checker #(
    parameter int NUM_VEC = 256,
    parameter int RSVD    = 16,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_en,
    input logic [VEC_W-1:0] set_vec,
    input logic             clr_en,
    input logic [VEC_W-1:0] clr_vec,
    input logic             set_dup,
    input logic             set_err,
    input logic             pending,
    input logic             top_valid,
    input logic [VEC_W:0]   top_vec
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!pending && !top_valid && !set_err && (&top_vec)));

    assert_dup_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_dup |-> (set_en && int'(set_vec) >= RSVD));

    assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && int'(set_vec) >= RSVD) |=> pending);

    assert_top_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (!top_vec[VEC_W] && int'(top_vec) >= RSVD));

    assert_none_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (!top_valid && (&top_vec)));

    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && int'(set_vec) < RSVD) |=> set_err);

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && int'(set_vec) < RSVD) |=> !set_err);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_vec == clr_vec && int'(set_vec) >= RSVD)
        |=> (top_valid && top_vec[VEC_W-1:0] >= $past(set_vec)));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> ($stable(top_vec) && $stable(pending)));
endmodule

bind pend_vec_tracker pvt_checker #(.NUM_VEC(NUM_VEC), .RSVD(RSVD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (set_en),
    .set_vec   (set_vec),
    .clr_en    (clr_en),
    .clr_vec   (clr_vec),
    .set_dup   (set_dup),
    .set_err   (set_err),
    .pending   (pending),
    .top_valid (top_valid),
    .top_vec   (top_vec)
);

// File: tb/pend_vec_tracker_tb.sv
`timescale 1ns/1ps
module pend_vec_tracker_tb;
    localparam int NONE   = 9'h1FF;
    localparam int WD_CYC = 200000;
    localparam int OP_SET = 0, OP_CLR = 1, OP_BOTH = 2, OP_IDLE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_en = 1'b0, clr_en = 1'b0;
    logic [7:0] set_vec = '0, clr_vec = '0;
    logic       set_dup, set_err, pending, top_valid;
    logic [8:0] top_vec;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pend_vec_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_vec(set_vec),
        .clr_en(clr_en), .clr_vec(clr_vec), .set_dup(set_dup),
        .set_err(set_err), .pending(pending), .top_valid(top_valid),
        .top_vec(top_vec)
    );

    // Entry layout: op[19:18] vec[17:10] dup[9] top[8:0]
    function automatic logic [19:0] mk(int op, int vec, int dup, int top);
        return {op[1:0], vec[7:0], dup[0], top[8:0]};
    endfunction

    localparam int NT = 16;
    localparam logic [19:0] TBL [NT] = '{
        mk(OP_SET, 40, 0, 40),     // R2
        mk(OP_SET, 200, 0, 200),   // R5
        mk(OP_SET, 40, 1, 200),    // R3 repeat
        mk(OP_SET, 100, 0, 200),   // R5
        mk(OP_CLR, 200, 0, 100),   // R6
        mk(OP_CLR, 77, 0, 100),    // R10
        mk(OP_SET, 16, 0, 100),    // R2 lowest legal
        mk(OP_CLR, 100, 0, 40),    // R6
        mk(OP_CLR, 40, 0, 16),     // R6
        mk(OP_BOTH, 255, 0, 255),  // R9
        mk(OP_CLR, 255, 0, 16),    // R6
        mk(OP_SET, 255, 0, 255),   // R3 new after clear
        mk(OP_CLR, 16, 0, 255),    // R6
        mk(OP_CLR, 255, 0, NONE),  // R6 empty
        mk(OP_IDLE, 0, 0, NONE),   // R7
        mk(OP_SET, 5, 0, NONE)     // R8 ignored
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; dup is sampled before the edge.
    task automatic apply(input int op, input int vec, output logic dup);
        @(negedge clk);
        set_en  = (op == OP_SET || op == OP_BOTH);
        clr_en  = (op == OP_CLR || op == OP_BOTH);
        set_vec = vec[7:0];
        clr_vec = vec[7:0];
        #1 dup = set_dup;
        @(posedge clk);
        #1;
        set_en = 1'b0;
        clr_en = 1'b0;
    endtask

    task automatic chk_top(input int exp, input string req);
        chk(top_vec == exp[8:0], req, top_vec, exp);
        chk(top_valid == (exp != NONE) && pending == (exp != NONE), req,
            {pending, top_valid}, (exp != NONE) ? 3 : 0);
    endtask

    initial begin
        logic d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_top(NONE, "R1");
        chk(set_err == 1'b0, "R1 set_err", set_err, 0);

        for (int i = 0; i < NT; i++) begin
            logic [19:0] e;
            e = TBL[i];
            apply(int'(e[19:18]), int'(e[17:10]), d);
            chk(d == e[9], "R3 set_dup", d, e[9]);
            chk_top(int'(e[8:0]), "R2/R5/R6/R9/R10 table");
        end
        // R8 pulse from the last table row, then quiet
        chk(set_err == 1'b1, "R8 pulse", set_err, 1);
        apply(OP_IDLE, 0, d);
        chk(set_err == 1'b0, "R8 one cycle", set_err, 0);

        // R8 with content present: reserved set leaves the query alone
        apply(OP_SET, 60, d);
        apply(OP_SET, 15, d);
        chk(set_err == 1'b1, "R8 pulse", set_err, 1);
        chk(d == 1'b0, "R3 reserved no dup", d, 0);
        chk_top(60, "R8 ignored");

        // R11: same-cycle query still shows old state
        @(negedge clk);
        set_en = 1'b1; set_vec = 8'd90;
        #1 chk(top_vec == 9'd60, "R11 same cycle", top_vec, 60);
        @(posedge clk); #1 set_en = 1'b0;
        chk_top(90, "R11 next cycle");
        chk(set_err == 1'b0, "R8 quiet", set_err, 0);

        // R4: duplicate set keeps pending, R3 dup seen
        apply(OP_SET, 90, d);
        chk(d == 1'b1, "R3 dup", d, 1);
        chk(pending == 1'b1, "R4", pending, 1);

        // R1 mid-run reset clears the bitmap
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk_top(NONE, "R1 mid-run");
        apply(OP_SET, 17, d);
        chk(d == 1'b0, "R1 bitmap cleared", d, 0);
        chk_top(17, "R1 bitmap cleared");

        // R9 with the bit already recorded
        apply(OP_BOTH, 17, d);
        chk(d == 1'b1, "R9 dup", d, 1);
        chk_top(17, "R9 set wins");
        apply(OP_CLR, 17, d);
        chk_top(NONE, "R6 empty");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(WD_CYC * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule